// File: doc/BRIEF.md
# Scanout Start-Address Latching Controller

This block produces the vertical timing of a raster display and holds the two scroll values that scanout reads: the frame-buffer start address and the fine pixel pan. It counts scanlines, one per pulse on `line_tick`, through four phases in turn: active lines, front porch, sync pulse and back porch. From that count it drives the blank and vsync outputs.

Software writes new scroll values into shadow registers through a small write port. Each shadow register is copied into the working register that scanout uses, and the copy happens only at one edge of the sync pulse. In the split mode, the start address is taken when the sync pulse begins and the pan is taken when it ends. With `lock_mode` high, both values are taken together when the sync pulse ends. A sticky flag is set when the sync pulse begins. The flag drives the interrupt output through an enable bit, and software clears it with a strobe.

Top module: `scan_latch_ctrl`

## Requirements
- R1: Line 0 after reset is the first active line. The line count advances by one on each `line_tick` and wraps to 0 after ACTIVE_LINES+FRONT_PORCH+SYNC_LINES+BACK_PORCH lines. `blank` is high exactly on lines ACTIVE_LINES and above.
- R2: `vsync` is high exactly on lines ACTIVE_LINES+FRONT_PORCH through ACTIVE_LINES+FRONT_PORCH+SYNC_LINES-1, so it only rises after the front porch lines.
- R3: The interrupt flag is set on the clock edge that moves the count onto the first sync line. Entering blanking (the front porch) does not set it.
- R4: The flag stays set until `irq_clr` is pulsed. If a set and a clear fall on the same edge, the set wins.
- R5: `irq` equals the flag ANDed with the interrupt-enable bit. The enable bit is bit 0 of the control register (`wr_sel`=2) and is 0 after reset.
- R6: A write with `wr_sel`=0 loads the start shadow from `wr_data`, and `wr_sel`=1 loads the pan shadow from `wr_data[3:0]`. A write never changes `start_addr` or `pan` directly. A write with `wr_sel`=3 changes nothing.
- R7: With `lock_mode` low, `start_addr` takes the start shadow on the edge that enters the first sync line.
- R8: In either mode, `pan` takes the pan shadow on the edge that leaves the last sync line.
- R9: With `lock_mode` low, if both shadows are written during sync, the new pan appears when that sync pulse ends and the new start address appears only at the next frame's sync start.
- R10: With `lock_mode` high, `start_addr` does not change at sync start. Both working registers load together when sync ends.
- R11: After reset, `start_addr`, `pan`, `irq` and `vsync` are 0, and `blank` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse that advances one scanline |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 start shadow, 1 pan shadow, 2 control, 3 none |
| wr_data | input | ADDR_W | Write data |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| lock_mode | input | 1 | 1: load both working registers at sync end |
| blank | output | 1 | High outside the active lines |
| vsync | output | 1 | High during the sync lines |
| irq | output | 1 | Gated vertical-sync interrupt |
| start_addr | output | ADDR_W | Working start address used by scanout |
| pan | output | PAN_W | Working pixel pan used by scanout |

## Verification
The assertions assume that `line_tick` is a one-cycle pulse. They also assume that `lock_mode` changes only when no sync edge is near, because the working-register checks compare each change against the mode held one cycle earlier. The bench keeps to both. It pulses `line_tick` with an idle cycle after each pulse, and it changes `lock_mode` only in the middle of active display. It also writes shadows only between ticks, so that no load edge ever sees a same-cycle write.

// File: rtl/scl_pkg.sv
// Shared types for the scanout start-address latching controller.
// Assumes nothing beyond a 2-bit write select on the register port.
package scl_pkg;

    // Targets of the register write port.
    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_PAN   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } wr_sel_e;

    // Bit positions inside the control register.
    localparam int CTRL_IRQ_EN_BIT = 0;

endpackage

// File: rtl/scl_vtiming.sv
// Vertical scanline counter. Advances once per line_tick and decodes blank and
// vsync from the count. Also flags the ticks that enter and leave the sync pulse.
// Assumes ACTIVE >= 1, FPORCH >= 1 and SYNC >= 1.
module scl_vtiming #(
    parameter int ACTIVE = 480,
    parameter int FPORCH = 10,
    parameter int SYNC   = 2,
    parameter int BPORCH = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    output logic blank,
    output logic vsync,
    output logic sync_enter,
    output logic sync_leave
);
    localparam int TOTAL      = ACTIVE + FPORCH + SYNC + BPORCH;
    localparam int LW         = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam int SYNC_FIRST = ACTIVE + FPORCH;
    localparam int SYNC_AFTER = SYNC_FIRST + SYNC;

    localparam logic [LW-1:0] L_LAST       = LW'(TOTAL - 1);
    localparam logic [LW-1:0] L_ACTIVE     = LW'(ACTIVE);
    localparam logic [LW-1:0] L_SYNC_FIRST = LW'(SYNC_FIRST);
    localparam logic [LW-1:0] L_SYNC_LAST  = LW'(SYNC_AFTER - 1);
    localparam logic [LW-1:0] L_PRE_SYNC   = LW'(SYNC_FIRST - 1);

    logic [LW-1:0] line_q;

    // Advance the line count on each tick and wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (line_tick) begin
            line_q <= (line_q == L_LAST) ? '0 : line_q + 1'b1;
        end
    end

    // Decode the phase outputs and the sync edge events from the count.
    always_comb begin
        blank      = (line_q >= L_ACTIVE);
        vsync      = (line_q >= L_SYNC_FIRST) && (line_q <= L_SYNC_LAST);
        sync_enter = line_tick && (line_q == L_PRE_SYNC);
        sync_leave = line_tick && (line_q == L_SYNC_LAST);
    end

endmodule

// File: rtl/scl_scroll_regs.sv
// Shadow and working registers for start address and pixel pan. Writes land in
// the shadows only, and the working copies load at sync edges. With lock_mode
// low the start address loads at sync entry; with lock_mode high it loads with
// the pan at sync exit. Assumes PAN_W <= ADDR_W.
module scl_scroll_regs
    import scl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              sync_enter,
    input  logic              sync_leave,
    input  logic              lock_mode,
    output logic [ADDR_W-1:0] start_addr,
    output logic [PAN_W-1:0]  pan
);
    logic [ADDR_W-1:0] start_sh_q;
    logic [PAN_W-1:0]  pan_sh_q;
    logic [ADDR_W-1:0] start_wk_q;
    logic [PAN_W-1:0]  pan_wk_q;
    logic              start_load;

    // Capture software writes into the shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_sh_q <= '0;
            pan_sh_q   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_START) start_sh_q <= wr_data;
            if (wr_sel == SEL_PAN)   pan_sh_q   <= wr_data[PAN_W-1:0];
        end
    end

    // Choose the sync edge that loads the start address.
    always_comb begin
        start_load = lock_mode ? sync_leave : sync_enter;
    end

    // Copy the start shadow into its working register on the chosen edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_wk_q <= '0;
        end else if (start_load) begin
            start_wk_q <= start_sh_q;
        end
    end

    // Copy the pan shadow into its working register at sync exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pan_wk_q <= '0;
        end else if (sync_leave) begin
            pan_wk_q <= pan_sh_q;
        end
    end

    assign start_addr = start_wk_q;
    assign pan        = pan_wk_q;

endmodule

// File: rtl/scl_irq.sv
// Sticky vertical-sync interrupt flag with an enable bit in the control
// register. A set on the same edge as a clear wins. Assumes one-cycle strobes.
module scl_irq
    import scl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic       wr_bit,
    input  logic       sync_enter,
    input  logic       irq_clr,
    output logic       flag,
    output logic       irq
);
    logic flag_q;
    logic en_q;

    // Hold the interrupt-enable control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                             en_q <= 1'b0;
        else if (wr_en && wr_sel == SEL_CTRL)   en_q <= wr_bit;
    end

    // Set the flag at sync entry, and clear it only on the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (sync_enter) flag_q <= 1'b1;
        else if (irq_clr)    flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = flag_q & en_q;

endmodule

// File: rtl/scan_latch_ctrl.sv
// Top of the scanout start-address latching controller: vertical timing,
// scroll shadow/working registers and the sticky sync interrupt.
// Assumes line_tick is a one-cycle pulse per scanline.
module scan_latch_ctrl
    import scl_pkg::*;
#(
    parameter int ACTIVE_LINES = 480,
    parameter int FRONT_PORCH  = 10,
    parameter int SYNC_LINES   = 2,
    parameter int BACK_PORCH   = 33,
    parameter int ADDR_W       = 16,
    parameter int PAN_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              irq_clr,
    input  logic              lock_mode,
    output logic              blank,
    output logic              vsync,
    output logic              irq,
    output logic [ADDR_W-1:0] start_addr,
    output logic [PAN_W-1:0]  pan
);
    logic sync_enter;
    logic sync_leave;
    logic irq_flag;

    scl_vtiming #(
        .ACTIVE (ACTIVE_LINES),
        .FPORCH (FRONT_PORCH),
        .SYNC   (SYNC_LINES),
        .BPORCH (BACK_PORCH)
    ) u_vtiming (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .blank      (blank),
        .vsync      (vsync),
        .sync_enter (sync_enter),
        .sync_leave (sync_leave)
    );

    scl_scroll_regs #(
        .ADDR_W (ADDR_W),
        .PAN_W  (PAN_W)
    ) u_scroll (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .sync_enter (sync_enter),
        .sync_leave (sync_leave),
        .lock_mode  (lock_mode),
        .start_addr (start_addr),
        .pan        (pan)
    );

    scl_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_bit     (wr_data[CTRL_IRQ_EN_BIT]),
        .sync_enter (sync_enter),
        .irq_clr    (irq_clr),
        .flag       (irq_flag),
        .irq        (irq)
    );

endmodule

// File: rtl/scl_checker.sv
// Temporal checks for scan_latch_ctrl, bound to every instance of it.
// Assumes lock_mode is steady for a cycle around each sync edge.
module scl_checker #(
    parameter int ADDR_W = 16,
    parameter int PAN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blank,
    input logic              vsync,
    input logic              irq,
    input logic              irq_flag,
    input logic              irq_clr,
    input logic              lock_mode,
    input logic [ADDR_W-1:0] start_addr,
    input logic [PAN_W-1:0]  pan
);
    // R2: the sync lines always lie inside blanking
    a_r2_vsync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> blank);

    // R3: the flag is set whenever the sync pulse starts
    a_r3_flag_at_sync_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> irq_flag);

    // R4: the flag holds while no clear strobe arrives
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R5: the interrupt output never shows without the flag
    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag);

    // R7: in split mode the start address changes only as sync starts
    a_r7_start_at_sync_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(start_addr) && !$past(lock_mode)) |-> $rose(vsync));

    // R10: in lock mode the start address changes only as sync ends
    a_r10_start_at_sync_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(start_addr) && $past(lock_mode)) |-> $fell(vsync));

    // R8: pan changes only as sync ends
    a_r8_pan_at_sync_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pan) |-> $fell(vsync));

endmodule

bind scan_latch_ctrl scl_checker #(
    .ADDR_W (ADDR_W),
    .PAN_W  (PAN_W)
) u_scl_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank      (blank),
    .vsync      (vsync),
    .irq        (irq),
    .irq_flag   (irq_flag),
    .irq_clr    (irq_clr),
    .lock_mode  (lock_mode),
    .start_addr (start_addr),
    .pan        (pan)
);

// File: tb/scan_latch_ctrl_bench.sv
// Self-checking bench: sweeps every line of several frames of a small timing
// configuration and compares all outputs against an arithmetic model.
module scan_latch_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ACT = 6;
    localparam int FP  = 2;
    localparam int SW  = 2;
    localparam int BP  = 3;
    localparam int TOT = ACT + FP + SW + BP;
    localparam int SF  = ACT + FP;
    localparam int SA  = SF + SW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        irq_clr = 1'b0;
    logic        lock_mode = 1'b0;
    logic        blank, vsync, irq;
    logic [15:0] start_addr;
    logic [3:0]  pan;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int          bl = 0;
    logic [15:0] sh_start = 0, ex_start = 0;
    logic [3:0]  sh_pan = 0, ex_pan = 0;
    logic        ex_flag = 0, ex_en = 0;

    scan_latch_ctrl #(
        .ACTIVE_LINES (ACT), .FRONT_PORCH (FP), .SYNC_LINES (SW),
        .BACK_PORCH (BP), .ADDR_W (16), .PAN_W (4)
    ) u_scan_latch_ctrl (
        .clk (clk), .rst_n (rst_n), .line_tick (line_tick), .wr_en (wr_en),
        .wr_sel (wr_sel), .wr_data (wr_data), .irq_clr (irq_clr),
        .lock_mode (lock_mode), .blank (blank), .vsync (vsync), .irq (irq),
        .start_addr (start_addr), .pan (pan)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s line=%0d actual=%0h expected=%0h", req, bl, act, exp);
        end
    endtask

    // Compare every output with the model after a line step.
    task automatic check_all();
        chk("R1 blank", 32'(blank), 32'(bl >= ACT));
        chk("R2 vsync", 32'(vsync), 32'(bl >= SF && bl < SA));
        chk("R5 irq", 32'(irq), 32'(ex_flag & ex_en));
        chk("R7 start", 32'(start_addr), 32'(ex_start));
        chk("R8 pan", 32'(pan), 32'(ex_pan));
    endtask

    // One scanline tick, optionally with a same-cycle clear.
    task automatic tick(input logic clr);
        int nl;
        @(negedge clk);
        line_tick = 1'b1;
        irq_clr = clr;
        @(negedge clk);
        line_tick = 1'b0;
        irq_clr = 1'b0;
        nl = (bl == TOT - 1) ? 0 : bl + 1;
        if (clr) ex_flag = 0;
        if (nl == SF) begin
            ex_flag = 1;
            if (!lock_mode) ex_start = sh_start;
        end
        if (nl == SA) begin
            ex_pan = sh_pan;
            if (lock_mode) ex_start = sh_start;
        end
        bl = nl;
        check_all();
    endtask

    task automatic advance_to(input int t);
        tick(1'b0);
        while (bl != t) tick(1'b0);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 2'd0) sh_start = d;
        if (sel == 2'd1) sh_pan = d[3:0];
        if (sel == 2'd2) ex_en = d[0];
        check_all();
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        ex_flag = 0;
        check_all();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 start", 32'(start_addr), 0);
        chk("R11 pan", 32'(pan), 0);
        chk("R11 irq", 32'(irq), 0);
        chk("R11 vsync", 32'(vsync), 0);
        chk("R11 blank", 32'(blank), 0);

        wr(2'd2, 16'h0001);
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'h0005);
        // R6: writes do not reach the working registers
        chk("R6 start", 32'(start_addr), 0);
        chk("R6 pan", 32'(pan), 0);

        advance_to(SF - 1);
        // R3: blanking begins without the interrupt
        chk("R3 blank no irq", 32'(irq), 0);
        chk("R3 in porch", 32'(blank), 1);
        tick(1'b0);
        chk("R3 irq at sync", 32'(irq), 1);
        chk("R7 start at sync", 32'(start_addr), 32'h1234);
        chk("R8 pan waits", 32'(pan), 0);

        advance_to(SF + 1);
        wr(2'd0, 16'hBEEF);
        wr(2'd1, 16'h0009);
        tick(1'b0);
        // R9: pan next frame, start deferred
        chk("R9 pan new", 32'(pan), 9);
        chk("R9 start old", 32'(start_addr), 32'h1234);

        advance_to(3);
        chk("R4 sticky", 32'(irq), 1);
        clear_irq();
        chk("R4 cleared", 32'(irq), 0);
        advance_to(SF);
        chk("R9 start deferred", 32'(start_addr), 32'hBEEF);

        // R5: disabled enable hides a set flag
        clear_irq();
        wr(2'd2, 16'h0000);
        advance_to(SF);
        chk("R5 gated", 32'(irq), 0);
        wr(2'd2, 16'h0001);
        chk("R5 enabled flag", 32'(irq), 1);
        clear_irq();

        // R10: lock mode loads both at sync end
        advance_to(3);
        lock_mode = 1'b1;
        wr(2'd0, 16'h0F0F);
        advance_to(SF);
        chk("R10 no load at start", 32'(start_addr), 32'hBEEF);
        advance_to(SF + 1);
        wr(2'd0, 16'hA5A5);
        wr(2'd1, 16'h0003);
        tick(1'b0);
        chk("R10 start", 32'(start_addr), 32'hA5A5);
        chk("R10 pan", 32'(pan), 3);

        // R4: set beats clear on the same edge
        clear_irq();
        advance_to(SF - 1);
        tick(1'b1);
        chk("R4 set wins", 32'(irq), 1);

        // R6: select 3 changes nothing
        wr(2'd3, 16'hFFFF);
        advance_to(3);
        lock_mode = 1'b0;
        advance_to(SA);
        chk("R6 sel3 start", 32'(start_addr), 32'hA5A5);
        chk("R6 sel3 pan", 32'(pan), 3);
        chk("R6 sel3 en", 32'(irq), 1);

        // R1: line count wraps to the first active line
        advance_to(0);
        chk("R1 wrap", 32'(blank), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule